// File: doc/BRIEF.md
# Bus-Master DMA Control Sequencer

This block is the control half of a bus-master DMA engine. Software loads three 32-bit registers through a small local control port: the start address on the system bus, the start address in local memory, and a control word. The control word sets the direction, the word width, the transfer length and the interrupt enables. It also carries the start bit and the completion flags. Once started, the block requests the system bus and waits for a grant. It then marks the start of the bus cycle and offers one data phase at a time on a valid/ready handshake. Each accepted word advances both addresses and lowers the remaining length.

Two backend inputs throttle the engine. A stall input keeps the bus cycle from starting, even with a grant present, until the backend is ready. A busy input ends a running transfer after a small fixed number of further words. The outcome is recorded as a done flag or a stopped flag. The interrupt output combines the done flag with its enable, and the external interrupt input with its enable.

The data-phase handshake follows valid/ready rules. `xfer_valid` stays high, and both addresses stay unchanged, until the bus side raises `xfer_ready`. The bus side may hold `xfer_ready` low for any number of cycles. A word counts as moved only on a clock edge where both signals are high.

Top module: `dma_seq_top`

## Requirements
- R1: The control port selects registers with `ctl_sel`: 0 is the bus address, 1 is the local address, 2 is the control word, and 3 reads as zero. A write takes effect on the clock edge where `ctl_cs_n` and `ctl_wr_n` are both low. Writes to the address registers are ignored while a transfer is active.
- R2: A read issued on a clock edge (with `ctl_cs_n` and `ctl_rd_n` both low) returns its data with `ctl_rvalid` high one cycle after the next edge, giving two cycles from address to data. In every other cycle `ctl_rvalid` is low and `ctl_rdata` is zero.
- R3: The control word has this layout: bit 0 start (write) / active (read), bit 1 direction (1 = local to bus), bit 2 done, bit 3 done-interrupt enable, bit 4 external-interrupt enable, bit 5 64-bit width, bit 6 stopped, bits 15..7 reserved, and bits 31..16 length in words. The reserved bits read as zero. The width bit reads as zero in a build without 64-bit support.
- R4: A control write with bit 0 set and a nonzero length, made while idle, raises `bus_req` in the next cycle. While a transfer is active, control writes change nothing except the clear-on-one of the done and stopped flags.
- R5: `bus_start` pulses for one cycle. It follows the first clock edge that sees `bus_gnt` high and `be_stall` low during the request. While `be_stall` is high, no bus cycle starts.
- R6: Each accepted word adds 4 to both addresses (or 8 when the 64-bit width bit is set) and lowers the length by one. While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid` and both addresses hold.
- R7: When the length reaches zero, `bus_req` drops and the done flag sets. Writing 1 to bit 2 clears the flag. If completion and the clear fall on the same edge, the flag ends up set.
- R8: After the edge where `be_busy` is first seen high in the data phase, exactly two further words are accepted if the length allows. Then `xfer_valid` falls, the stopped flag sets, and done stays clear. Writing 1 to bit 6 clears the stopped flag.
- R9: A start with a length of zero sets the done flag two edges later and never raises `bus_req`.
- R10: `irq` is high exactly when (done and bit 3) or (bit 4 and `ext_irq`).
- R11: After reset, all registers read as zero and `bus_req`, `bus_start`, `xfer_valid`, `irq` and `ctl_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_cs_n | input | 1 | Control port select, active low |
| ctl_wr_n | input | 1 | Control port write strobe, active low |
| ctl_rd_n | input | 1 | Control port read strobe, active low |
| ctl_sel | input | 2 | Register select |
| ctl_wdata | input | 32 | Register write data |
| ctl_rdata | output | 32 | Register read data, zero when not valid |
| ctl_rvalid | output | 1 | Read data valid |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_start | output | 1 | One-cycle pulse marking the start of the bus cycle |
| bus_addr | output | 32 | Current system bus address |
| bus_dir_wr | output | 1 | Direction: 1 = local memory to bus |
| bus_wide | output | 1 | 64-bit data phases selected |
| mem_addr | output | 32 | Current local memory address |
| xfer_valid | output | 1 | A data phase is offered |
| xfer_ready | input | 1 | Bus side accepts the data phase |
| be_stall | input | 1 | Backend holds off the start of the bus cycle |
| be_busy | input | 1 | Backend asks the running transfer to stop |
| ext_irq | input | 1 | External interrupt request, active high |
| irq | output | 1 | Interrupt output |

## Verification
The delicate overlap is completion of the last word against a software write that clears the done flag. Both act on the flag on the same clock edge. The bench counts edges from the observed `bus_start` pulse and places a clear-on-one write on the exact edge where the engine leaves its final state. It then reads the control word back: the flag must still be set, and a second clear made one edge later must remove it. A second overlap is a busy request that arrives while a word is being accepted. The bench checks that this word is counted before the two-word drain begins, by comparing the total number of handshakes and the final addresses and length.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int REG_W = 32;

  // register select codes on the control port
  localparam logic [1:0] SEL_BUS = 2'd0;
  localparam logic [1:0] SEL_MEM = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;

  // control word bit positions
  localparam int CB_GO      = 0;
  localparam int CB_DIR     = 1;
  localparam int CB_DONE    = 2;
  localparam int CB_DONE_IE = 3;
  localparam int CB_EXT_IE  = 4;
  localparam int CB_WIDE    = 5;
  localparam int CB_STOP    = 6;
  localparam int CB_CFG_TOP = 6;
  localparam int CB_LEN_LO  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] INC_NARROW = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] INC_WIDE   = ADDR_W'(8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step) begin
      addr <= addr + (wide ? INC_WIDE : INC_NARROW);
    end
  end

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_bus,
  input  logic              ld_mem,
  input  logic              ld_len,
  input  logic [31:0]       wdata,
  input  logic              step,
  input  logic              wide,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  len,
  output logic              len_one
);
  import dma_seq_pkg::*;

  localparam int N_PTR = 2;

  logic [N_PTR-1:0]  ld_vec;
  logic [ADDR_W-1:0] ptr_q [N_PTR];

  assign ld_vec = {ld_mem, ld_bus};

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    dma_addr_reg #(.ADDR_W(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_vec[g]),
      .load_val (wdata[ADDR_W-1:0]),
      .step     (step),
      .wide     (wide),
      .addr     (ptr_q[g])
    );
  end

  assign bus_addr = ptr_q[0];
  assign mem_addr = ptr_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0;
    end else if (ld_len) begin
      len <= wdata[CB_LEN_LO +: LEN_W];
    end else if (step) begin
      len <= len - LEN_W'(1);
    end
  end

  assign len_one = (len == LEN_W'(1));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm #(
  parameter int STOP_SLACK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_empty,
  input  logic len_one,
  input  logic bus_gnt,
  input  logic be_stall,
  input  logic be_busy,
  input  logic xfer_ready,
  output logic bus_req,
  output logic bus_start,
  output logic xfer_valid,
  output logic step,
  output logic fin_done,
  output logic fin_stop,
  output logic active,
  output logic in_data
);
  import dma_seq_pkg::*;

  localparam int SW = (STOP_SLACK < 1) ? 1 : $clog2(STOP_SLACK + 1);
  localparam logic [SW-1:0] SLACK_INIT = SW'(STOP_SLACK);

  seq_state_e    state_q, state_d;
  logic          stopping_q;
  logic [SW-1:0] slack_q;
  logic          fin_ok_q, fin_ok_d;
  logic          drain_end;

  always_comb begin
    in_data    = (state_q == ST_DATA);
    active     = (state_q != ST_IDLE);
    bus_req    = (state_q == ST_REQ) || (state_q == ST_ADDR) || in_data;
    bus_start  = (state_q == ST_ADDR);
    xfer_valid = in_data && (!stopping_q || (slack_q != '0));
    step       = xfer_valid && xfer_ready;
    fin_done   = (state_q == ST_FIN) && fin_ok_q;
    fin_stop   = (state_q == ST_FIN) && !fin_ok_q;
    drain_end  = stopping_q && ((slack_q == '0) || (step && (slack_q == SW'(1))));
  end

  always_comb begin
    state_d  = state_q;
    fin_ok_d = fin_ok_q;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d  = go_empty ? ST_FIN : ST_REQ;
          fin_ok_d = 1'b1;
        end
      end
      ST_REQ: begin
        if (bus_gnt && !be_stall) state_d = ST_ADDR;
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (step && len_one) begin
          state_d  = ST_FIN;
          fin_ok_d = 1'b1;
        end else if (drain_end) begin
          state_d  = ST_FIN;
          fin_ok_d = 1'b0;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fin_ok_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      fin_ok_q <= fin_ok_d;
    end
  end

  // drain window opened by the busy input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopping_q <= 1'b0;
      slack_q    <= '0;
    end else if (state_q != ST_DATA) begin
      stopping_q <= 1'b0;
      slack_q    <= '0;
    end else if (!stopping_q && be_busy) begin
      stopping_q <= 1'b1;
      slack_q    <= SLACK_INIT;
    end else if (stopping_q && step) begin
      slack_q    <= slack_q - SW'(1);
    end
  end

endmodule

// File: rtl/dma_ctl_port.sv
module dma_ctl_port #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter bit WIDE_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    wr_n,
  input  logic                    rd_n,
  input  logic [1:0]              sel,
  input  logic [6:0]              cfg_bits,
  input  logic                    active,
  input  logic                    fin_done,
  input  logic                    fin_stop,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [ADDR_W-1:0]       mem_addr,
  input  logic [LEN_W-1:0]        len,
  output logic                    ld_bus,
  output logic                    ld_mem,
  output logic                    ld_cfg,
  output logic                    go,
  output logic                    dir,
  output logic                    wide,
  output logic                    done,
  output logic                    stopped,
  output logic                    done_ie,
  output logic                    ext_ie,
  output logic [31:0]             rdata,
  output logic                    rvalid
);
  import dma_seq_pkg::*;

  logic        wr_hit, clr_hit;
  logic        rd_p1;
  logic [1:0]  sel_p1;
  logic [31:0] ctl_word;
  logic [31:0] rd_mux;

  assign wr_hit  = !cs_n && !wr_n;
  assign clr_hit = wr_hit && (sel == SEL_CTL);
  assign ld_bus  = wr_hit && (sel == SEL_BUS) && !active;
  assign ld_mem  = wr_hit && (sel == SEL_MEM) && !active;
  assign ld_cfg  = clr_hit && !active;
  assign go      = ld_cfg && cfg_bits[CB_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir     <= 1'b0;
      wide    <= 1'b0;
      done_ie <= 1'b0;
      ext_ie  <= 1'b0;
    end else if (ld_cfg) begin
      dir     <= cfg_bits[CB_DIR];
      wide    <= WIDE_EN && cfg_bits[CB_WIDE];
      done_ie <= cfg_bits[CB_DONE_IE];
      ext_ie  <= cfg_bits[CB_EXT_IE];
    end
  end

  // status flags: a set from the sequencer wins over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      stopped <= 1'b0;
    end else begin
      if (fin_done)                             done    <= 1'b1;
      else if (clr_hit && cfg_bits[CB_DONE])    done    <= 1'b0;
      if (fin_stop)                             stopped <= 1'b1;
      else if (clr_hit && cfg_bits[CB_STOP])    stopped <= 1'b0;
    end
  end

  always_comb begin
    ctl_word                       = '0;
    ctl_word[CB_GO]                = active;
    ctl_word[CB_DIR]               = dir;
    ctl_word[CB_DONE]              = done;
    ctl_word[CB_DONE_IE]           = done_ie;
    ctl_word[CB_EXT_IE]            = ext_ie;
    ctl_word[CB_WIDE]              = wide;
    ctl_word[CB_STOP]              = stopped;
    ctl_word[CB_LEN_LO +: LEN_W]   = len;
  end

  always_comb begin
    case (sel_p1)
      SEL_BUS: rd_mux = 32'(bus_addr);
      SEL_MEM: rd_mux = 32'(mem_addr);
      SEL_CTL: rd_mux = ctl_word;
      default: rd_mux = '0;
    endcase
  end

  // two-stage read pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p1  <= 1'b0;
      sel_p1 <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rd_p1  <= !cs_n && !rd_n;
      sel_p1 <= sel;
      rvalid <= rd_p1;
      rdata  <= rd_p1 ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter bit WIDE_EN    = 1'b1,
  parameter int STOP_SLACK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_cs_n,
  input  logic              ctl_wr_n,
  input  logic              ctl_rd_n,
  input  logic [1:0]        ctl_sel,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  output logic              ctl_rvalid,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_dir_wr,
  output logic              bus_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  input  logic              be_stall,
  input  logic              be_busy,
  input  logic              ext_irq,
  output logic              irq
);
  import dma_seq_pkg::*;

  logic             ld_bus, ld_mem, ld_cfg, go, go_empty;
  logic             dir, wide, done_flag, stopped, done_ie, ext_ie;
  logic             step, fin_done, fin_stop, active, in_data, len_one;
  logic [LEN_W-1:0] len;

  assign go_empty = (ctl_wdata[CB_LEN_LO +: LEN_W] == '0);

  dma_ctl_port #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WIDE_EN(WIDE_EN)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (ctl_cs_n),
    .wr_n     (ctl_wr_n),
    .rd_n     (ctl_rd_n),
    .sel      (ctl_sel),
    .cfg_bits (ctl_wdata[CB_CFG_TOP:0]),
    .active   (active),
    .fin_done (fin_done),
    .fin_stop (fin_stop),
    .bus_addr (bus_addr),
    .mem_addr (mem_addr),
    .len      (len),
    .ld_bus   (ld_bus),
    .ld_mem   (ld_mem),
    .ld_cfg   (ld_cfg),
    .go       (go),
    .dir      (dir),
    .wide     (wide),
    .done     (done_flag),
    .stopped  (stopped),
    .done_ie  (done_ie),
    .ext_ie   (ext_ie),
    .rdata    (ctl_rdata),
    .rvalid   (ctl_rvalid)
  );

  dma_xfer_count #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_bus   (ld_bus),
    .ld_mem   (ld_mem),
    .ld_len   (ld_cfg),
    .wdata    (ctl_wdata),
    .step     (step),
    .wide     (wide),
    .bus_addr (bus_addr),
    .mem_addr (mem_addr),
    .len      (len),
    .len_one  (len_one)
  );

  dma_seq_fsm #(.STOP_SLACK(STOP_SLACK)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_empty   (go_empty),
    .len_one    (len_one),
    .bus_gnt    (bus_gnt),
    .be_stall   (be_stall),
    .be_busy    (be_busy),
    .xfer_ready (xfer_ready),
    .bus_req    (bus_req),
    .bus_start  (bus_start),
    .xfer_valid (xfer_valid),
    .step       (step),
    .fin_done   (fin_done),
    .fin_stop   (fin_stop),
    .active     (active),
    .in_data    (in_data)
  );

  assign bus_dir_wr = dir;
  assign bus_wide   = wide;
  assign irq        = (done_flag && done_ie) || (ext_ie && ext_irq);

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int STOP_SLACK = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_cs_n,
  input logic              ctl_rd_n,
  input logic              ctl_rvalid,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_start,
  input logic              be_stall,
  input logic              be_busy,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              bus_wide,
  input logic              done_flag,
  input logic              active,
  input logic              in_data
);

  logic       busy_seen;
  logic [7:0] post_words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_seen  <= 1'b0;
      post_words <= '0;
    end else if (!active) begin
      busy_seen  <= 1'b0;
      post_words <= '0;
    end else begin
      if (busy_seen && xfer_valid && xfer_ready) post_words <= post_words + 8'd1;
      if (in_data && be_busy) busy_seen <= 1'b1;
    end
  end

  p_start_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> $past(bus_gnt && !be_stall));

  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);

  p_hold_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> ($stable(bus_addr) && $stable(mem_addr)));

  p_valid_persists_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((STOP_SLACK > 0) && xfer_valid && !xfer_ready) |=> xfer_valid);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=>
      ((bus_addr - $past(bus_addr)) == ($past(bus_wide) ? ADDR_W'(8) : ADDR_W'(4))));

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rvalid |-> $past(!ctl_cs_n && !ctl_rd_n, 2));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> !bus_req);

  p_drain_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(post_words) <= STOP_SLACK));

endmodule

bind dma_seq_top dma_seq_chk #(.ADDR_W(ADDR_W), .STOP_SLACK(STOP_SLACK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_cs_n   (ctl_cs_n),
  .ctl_rd_n   (ctl_rd_n),
  .ctl_rvalid (ctl_rvalid),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_start  (bus_start),
  .be_stall   (be_stall),
  .be_busy    (be_busy),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .bus_addr   (bus_addr),
  .mem_addr   (mem_addr),
  .bus_wide   (bus_wide),
  .done_flag  (done_flag),
  .active     (active),
  .in_data    (in_data)
);

// File: tb/dma_seq_top_tb_top.sv
`timescale 1ns/1ps
module dma_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_cs_n = 1'b1, ctl_wr_n = 1'b1, ctl_rd_n = 1'b1;
  logic [1:0]  ctl_sel = '0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        ctl_rvalid;
  logic        bus_req, bus_start, bus_dir_wr, bus_wide, xfer_valid, irq;
  logic        bus_gnt = 1'b1, be_stall = 1'b0, be_busy = 1'b0, ext_irq = 1'b0;
  logic        xfer_ready = 1'b1;
  logic [31:0] bus_addr, mem_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int ready_mode = 0;
  int hs_cnt = 0, start_cnt = 0, req_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_seq_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_cs_n(ctl_cs_n), .ctl_wr_n(ctl_wr_n), .ctl_rd_n(ctl_rd_n),
    .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_rvalid(ctl_rvalid),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_dir_wr(bus_dir_wr), .bus_wide(bus_wide), .mem_addr(mem_addr),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .be_stall(be_stall), .be_busy(be_busy), .ext_irq(ext_irq), .irq(irq)
  );

  always @(posedge clk) begin
    #1;
    if (ready_mode == 1) xfer_ready = ~xfer_ready;
    else xfer_ready = (ready_mode == 0);
  end

  always @(negedge clk) begin
    if (xfer_valid && xfer_ready) hs_cnt++;
    if (bus_start) start_cnt++;
    if (bus_req) req_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_now(input logic [1:0] s, input logic [31:0] d);
    ctl_cs_n = 1'b0; ctl_wr_n = 1'b0; ctl_sel = s; ctl_wdata = d;
    @(posedge clk); #1;
    ctl_cs_n = 1'b1; ctl_wr_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    wr_now(s, d);
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(posedge clk); #1;
    ctl_cs_n = 1'b0; ctl_rd_n = 1'b0; ctl_sel = s;
    @(posedge clk); #1;
    ctl_cs_n = 1'b1; ctl_rd_n = 1'b1;
    @(negedge clk);
    chk("R2 rvalid one cycle after address", {31'b0, ctl_rvalid}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R2 rvalid two cycles after address", {31'b0, ctl_rvalid}, 32'd1);
    d = ctl_rdata;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 60 && !bus_start; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk("R11 bus_req after reset", {31'b0, bus_req}, 32'd0);
    chk("R11 xfer_valid after reset", {31'b0, xfer_valid}, 32'd0);
    chk("R11 irq after reset", {31'b0, irq}, 32'd0);
    chk("R11 rvalid/rdata after reset", {ctl_rvalid, ctl_rdata[30:0]}, 32'd0);
    rd(2'd2, v); chk("R11 control word after reset", v, 32'd0);
    rd(2'd0, v); chk("R11 bus address after reset", v, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(2'd0, 32'h1000_0000);
    wr(2'd1, 32'h0000_2000);
    rd(2'd0, v); chk("R1 bus address readback", v, 32'h1000_0000);
    rd(2'd1, v); chk("R1 local address readback", v, 32'h0000_2000);
    rd(2'd3, v); chk("R1 select 3 reads zero", v, 32'd0);
    wr(2'd2, 32'h0005_FFFE);
    rd(2'd2, v); chk("R3 control layout, reserved bits zero", v, 32'h0005_003A);
    wr(2'd2, 32'h0000_0000);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    int base;
    wr(2'd0, 32'h4000_0100);
    wr(2'd1, 32'h0000_0800);
    base = hs_cnt;
    wr(2'd2, 32'h0004_000B);
    @(negedge clk);
    chk("R4 bus_req follows start", {31'b0, bus_req}, 32'd1);
    wait_start();
    chk("R6 direction output", {30'b0, bus_dir_wr, bus_wide}, 32'd2);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R6 narrow word count", 32'(hs_cnt - base), 32'd4);
    chk("R7 bus_req dropped at end", {31'b0, bus_req}, 32'd0);
    chk("R10 irq from done", {31'b0, irq}, 32'd1);
    rd(2'd0, v); chk("R6 bus address +16", v, 32'h4000_0110);
    rd(2'd1, v); chk("R6 local address +16", v, 32'h0000_0810);
    rd(2'd2, v); chk("R7 done set, length zero", v, 32'h0000_000E);
    wr(2'd2, 32'h0000_0004);
    rd(2'd2, v); chk("R7 done cleared by write one", v, 32'd0);
  endtask

  task automatic t_wide_bp();
    logic [31:0] v;
    int base;
    wr(2'd0, 32'h2000_0000);
    wr(2'd1, 32'h0000_0000);
    base = hs_cnt;
    ready_mode = 1;
    wr(2'd2, 32'h0003_0021);
    repeat (40) @(posedge clk);
    ready_mode = 0;
    @(negedge clk);
    chk("R6 wide word count with back-pressure", 32'(hs_cnt - base), 32'd3);
    rd(2'd0, v); chk("R6 wide bus address +24", v, 32'h2000_0018);
    rd(2'd1, v); chk("R6 wide local address +24", v, 32'h0000_0018);
    rd(2'd2, v); chk("R7 wide done", v, 32'h0000_0024);
    wr(2'd2, 32'h0000_0044);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    int sbase;
    bus_gnt = 1'b0; be_stall = 1'b1;
    wr(2'd0, 32'h3000_0000);
    sbase = start_cnt;
    wr(2'd2, 32'h0002_0001);
    repeat (3) @(posedge clk);
    #1 bus_gnt = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 no start while stalled", 32'(start_cnt - sbase), 32'd0);
    chk("R5 request held while stalled", {31'b0, bus_req}, 32'd1);
    wr(2'd0, 32'hDEAD_0000);
    wr(2'd2, 32'h0009_0000);
    rd(2'd0, v); chk("R1 address write ignored while active", v, 32'h3000_0000);
    rd(2'd2, v); chk("R4 control write ignored while active", v, 32'h0002_0001);
    @(posedge clk); #1 be_stall = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R5 start one edge after stall release", {31'b0, bus_start}, 32'd1);
    repeat (10) @(posedge clk);
    rd(2'd0, v); chk("R5 transfer ran after release", v, 32'h3000_0008);
    wr(2'd2, 32'h0000_0004);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    int base;
    wr(2'd0, 32'h5000_0000);
    base = hs_cnt;
    wr(2'd2, 32'h000A_0009);
    wait_start();
    @(posedge clk); @(posedge clk); @(posedge clk);
    #1 be_busy = 1'b1;
    repeat (12) @(posedge clk);
    #1 be_busy = 1'b0;
    @(negedge clk);
    chk("R8 words: 3 before busy plus 2 drain", 32'(hs_cnt - base), 32'd5);
    chk("R8 no done irq after stop", {31'b0, irq}, 32'd0);
    rd(2'd0, v); chk("R8 bus address after stop", v, 32'h5000_0014);
    rd(2'd2, v); chk("R8 stopped set, done clear, length left", v, 32'h0005_0048);
    wr(2'd2, 32'h0000_0040);
    rd(2'd2, v); chk("R8 stopped cleared by write one", v, 32'h0000_0000);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(2'd2, 32'h0002_0001);
    wait_start();
    @(posedge clk); @(posedge clk); @(posedge clk);
    #1 wr_now(2'd2, 32'h0000_0004);
    rd(2'd2, v); chk("R7 set wins over same-edge clear", v, 32'h0000_0004);
    wr(2'd2, 32'h0000_0004);
    rd(2'd2, v); chk("R7 later clear removes done", v, 32'h0000_0000);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int rbase;
    rbase = req_cnt;
    wr(2'd2, 32'h0000_0009);
    @(negedge clk);
    chk("R9 not done after first edge", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R9 zero length done on second edge", {31'b0, irq}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R9 bus never requested", 32'(req_cnt - rbase), 32'd0);
    rd(2'd2, v); chk("R9 control word after zero length", v, 32'h0000_000C);
    wr(2'd2, 32'h0000_0004);
  endtask

  task automatic t_irq();
    ext_irq = 1'b1;
    @(negedge clk);
    chk("R10 external input masked", {31'b0, irq}, 32'd0);
    wr(2'd2, 32'h0000_0010);
    @(negedge clk);
    chk("R10 external input enabled", {31'b0, irq}, 32'd1);
    @(posedge clk); #1 ext_irq = 1'b0;
    @(negedge clk);
    chk("R10 external input released", {31'b0, irq}, 32'd0);
    wr(2'd2, 32'h0000_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_narrow();
    t_wide_bp();
    t_stall();
    t_busy();
    t_race();
    t_zero();
    t_irq();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule